// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block paces a serial transmitter and receiver. It turns the functional clock into an oversample tick, and into a bit-period tick once every oversampling-factor oversample ticks. The clock first goes through a small integer prescaler. A fixed-point divisor then sets the spacing of the oversample ticks. The divisor has a 16-bit whole part and a 6-bit fraction in steps of 1/64. The fraction is spread over successive periods by a 6-bit phase accumulator. Some periods therefore last one prescaled clock longer, and the average spacing comes out at the exact fractional value.

Software computes the divisor for the baud rate it wants. It loads the prescaler code, the divisor halves and the oversampling selection through a narrow write port. Every write is refused unless the generator is disabled and the transmitter reports idle. Disabling the generator clears all of its counters. After that, the first tick after enabling always comes one full period later.

Top module: `baud_tick_gen`

## Requirements
- R1: The prescaler code is written at address 2, bits [2:0]. A code c divides the functional clock by c+1, which multiplies every tick interval by c+1.
- R2: Each divisor period lasts W or W+1 prescaled clocks, where W is the whole part (address 0, bits [15:0]) and F is the fraction (address 1, bits [5:0]). Before each period, F is added to a 6-bit accumulator that starts at zero, and a carry out of that sum lengthens the period by one. Over any 64 consecutive periods from enable, the total is 64*W+F prescaled clocks.
- R3: While the whole part W is zero, no oversample tick and no bit tick is produced, whatever the fraction.
- R4: The oversampling selection is written at address 3, bits [1:0]. Codes 0, 1 and 2 give factors 16, 8 and 3. `bit_tick` is high together with every factor-th `os_tick` after enable, and at no other time. A write of code 3 is ignored.
- R5: A write of code 2 (factor 3) to address 3 is ignored while `coded_mode` is high.
- R6: A configuration write is ignored while `enable` is high or `tx_active` is high.
- R7: No tick is produced while disabled. Disabling clears the prescaler, the period counter, the accumulator and the oversample counter. The first `os_tick` is high exactly (c+1)*W clock edges after the first edge that samples `enable` high.
- R8: After reset both outputs are low, W=0, F=0, the prescaler code is 0 and the factor is 16.
- R9: With W=130, F=13, prescaler code 0 and factor 16, the 64th oversample tick comes 8333 clocks after enable. This gives an average bit period of 2083.25 clocks, which is 19200 baud within 0.01 % from a 40 MHz clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the generator; low clears its counters |
| tx_active | input | 1 | Transmitter busy; blocks configuration writes |
| coded_mode | input | 1 | Line coding or infrared mode active; forbids factor 3 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 whole, 1 fraction, 2 prescaler, 3 oversampling |
| cfg_wdata | input | 16 | Write data |
| os_tick | output | 1 | One-cycle oversample tick |
| bit_tick | output | 1 | One-cycle bit-period tick, coincident with an oversample tick |

## Verification
The bench loads random combinations of prescaler code, whole part, fraction and factor. For each one it predicts the clock edge of every oversample tick and bit tick from the accumulator rule. This separates a missing or misplaced carry, a wrong prescaler ratio and a wrong factor, because each of these shifts a different subset of tick positions. Directed cases pin down the rest. A fraction of zero shows plain integer division. A whole part of one with the largest prescaler shows the corner of the period counter. The reference divisor fixes the 64-period total. Writes made while enabled, while the transmitter is busy, of the reserved code, or of factor 3 under line coding are shown to be ignored by the unchanged tick timing that follows. A disable in mid-period is shown to restart the phase.

// File: rtl/baud_gen_pkg.sv
// Shared definitions for the fractional baud tick generator.
// Assumes a two-bit register select and at most a 16x oversampling factor.
package baud_gen_pkg;

    localparam int CFG_AW      = 2;
    localparam int OS_FACTOR_W = 5;

    typedef enum logic [1:0] {
        OSR_X16  = 2'd0,
        OSR_X8   = 2'd1,
        OSR_X3   = 2'd2,
        OSR_RSVD = 2'd3
    } osr_sel_e;

    typedef enum logic [CFG_AW-1:0] {
        ADDR_WHOLE = 2'd0,
        ADDR_FRAC  = 2'd1,
        ADDR_PRE   = 2'd2,
        ADDR_OSR   = 2'd3
    } cfg_addr_e;

    // Maps an oversampling selection onto its factor; the reserved code falls back to 16.
    function automatic logic [OS_FACTOR_W-1:0] osr_factor(input osr_sel_e sel);
        case (sel)
            OSR_X8:  osr_factor = 5'd8;
            OSR_X3:  osr_factor = 5'd3;
            default: osr_factor = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
// Configuration registers of the baud tick generator.
// Takes a write only when the generator is disabled and the transmitter is idle.
// Refuses the reserved oversampling code, and refuses factor 3 while line coding is active.
module baud_cfg_regs
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6,
    parameter int PRE_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tx_active,
    input  logic                 coded_mode,
    input  logic                 cfg_wr,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [INT_W-1:0]     cfg_wdata,
    output logic [INT_W-1:0]     div_whole,
    output logic [FRAC_W-1:0]    div_frac,
    output logic [PRE_W-1:0]     pre_code,
    output osr_sel_e             osr_sel
);

    logic     wr_open;
    osr_sel_e osr_new;
    logic     osr_legal;

    // Decide whether this write may land and whether its oversampling code is legal.
    always_comb begin
        wr_open   = cfg_wr && !enable && !tx_active;
        osr_new   = osr_sel_e'(cfg_wdata[1:0]);
        osr_legal = (osr_new != OSR_RSVD) && !((osr_new == OSR_X3) && coded_mode);
    end

    // Hold the four configuration fields, updating the addressed one on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_whole <= '0;
            div_frac  <= '0;
            pre_code  <= '0;
            osr_sel   <= OSR_X16;
        end else if (wr_open) begin
            case (cfg_addr_e'(cfg_addr))
                ADDR_WHOLE: div_whole <= cfg_wdata;
                ADDR_FRAC:  div_frac  <= cfg_wdata[FRAC_W-1:0];
                ADDR_PRE:   pre_code  <= cfg_wdata[PRE_W-1:0];
                default: begin
                    if (osr_legal) begin
                        osr_sel <= osr_new;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/baud_prescaler.sv
// Integer prescaler that pulses once every (pre_code+1) clocks while enabled.
// Assumes the code is stable while enabled; disabling restarts the count.
module baud_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PRE_W-1:0] pre_code,
    output logic             pre_tick
);

    logic [PRE_W-1:0] cnt_q;

    // Flag the last clock of each prescaled period.
    always_comb begin
        pre_tick = enable && (cnt_q == pre_code);
    end

    // Count clocks within a prescaled period, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/baud_frac_div.sv
// Fractional divider that counts prescaled clocks into divisor periods.
// A period lasts the whole part, plus one when adding the fraction to the phase
// accumulator carries out. A zero whole part stops all periods.
module baud_frac_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pre_tick,
    input  logic [INT_W-1:0]  div_whole,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              os_strobe
);

    localparam logic [INT_W:0] ONE_W = {{INT_W{1'b0}}, 1'b1};

    logic [INT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic              run;
    logic              period_end;

    // Work out this period's length from the accumulator carry and flag its last prescaled clock.
    always_comb begin
        acc_sum    = {1'b0, acc_q} + {1'b0, div_frac};
        carry      = acc_sum[FRAC_W];
        run        = enable && (div_whole != '0);
        period_end = (({1'b0, cnt_q} + ONE_W) == ({1'b0, div_whole} + {{INT_W{1'b0}}, carry}));
        os_strobe  = run && pre_tick && period_end;
    end

    // Advance the period counter and the phase accumulator, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (run && pre_tick) begin
            if (period_end) begin
                cnt_q <= '0;
                acc_q <= acc_sum[FRAC_W-1:0];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/baud_os_counter.sv
// Counts oversample strobes and flags every factor-th one as the end of a bit.
// Assumes the selection is stable while enabled; disabling restarts the count.
module baud_os_counter
    import baud_gen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     os_strobe,
    input  osr_sel_e osr_sel,
    output logic     bit_strobe
);

    logic [OS_FACTOR_W-1:0] cnt_q;
    logic [OS_FACTOR_W-1:0] factor;
    logic                   last;

    // Detect the final oversample of a bit.
    always_comb begin
        factor     = osr_factor(osr_sel);
        last       = (cnt_q == (factor - 5'd1));
        bit_strobe = os_strobe && last;
    end

    // Count oversample strobes within a bit, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (os_strobe) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
// Top of the fractional baud tick generator: prescaler, fractional divider and
// oversample counter, with registered one-cycle tick outputs.
// Assumes configuration is written only while the generator is disabled.
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_active,
    input  logic              coded_mode,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [INT_W-1:0]  cfg_wdata,
    output logic              os_tick,
    output logic              bit_tick
);

    logic [INT_W-1:0]  div_whole_q;
    logic [FRAC_W-1:0] div_frac_q;
    logic [PRE_W-1:0]  pre_code_q;
    osr_sel_e          osr_sel_q;
    logic              pre_tick;
    logic              os_strobe;
    logic              bit_strobe;

    baud_cfg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tx_active  (tx_active),
        .coded_mode (coded_mode),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .div_whole  (div_whole_q),
        .div_frac   (div_frac_q),
        .pre_code   (pre_code_q),
        .osr_sel    (osr_sel_q)
    );

    baud_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pre_code (pre_code_q),
        .pre_tick (pre_tick)
    );

    baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .pre_tick  (pre_tick),
        .div_whole (div_whole_q),
        .div_frac  (div_frac_q),
        .os_strobe (os_strobe)
    );

    baud_os_counter i_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .os_strobe  (os_strobe),
        .osr_sel    (osr_sel_q),
        .bit_strobe (bit_strobe)
    );

    // Register both ticks so that they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            os_tick  <= os_strobe;
            bit_tick <= bit_strobe;
        end
    end

endmodule

// File: rtl/baud_tick_gen_chk.sv
// Property checker for the baud tick generator, bound to the top module.
// Observes the ports and the held configuration fields.
module baud_tick_gen_chk
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6,
    parameter int PRE_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              tx_active,
    input logic              coded_mode,
    input logic              cfg_wr,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [INT_W-1:0]  cfg_wdata,
    input logic              os_tick,
    input logic              bit_tick,
    input logic [INT_W-1:0]  div_whole,
    input logic [FRAC_W-1:0] div_frac,
    input logic [PRE_W-1:0]  pre_code,
    input osr_sel_e          osr_sel
);

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> $past(enable));

    assert_bit_on_os_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    assert_zero_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_whole) == '0) |-> !os_tick);

    assert_locked_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (enable || tx_active)) |=>
            ($stable(div_whole) && $stable(div_frac) && $stable(pre_code) && $stable(osr_sel)));

    assert_no_x3_coded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && coded_mode && (cfg_addr == 2'd3) && (cfg_wdata[1:0] == 2'd2)) |=> $stable(osr_sel));

    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        osr_sel != OSR_RSVD);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tx_active  (tx_active),
    .coded_mode (coded_mode),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .os_tick    (os_tick),
    .bit_tick   (bit_tick),
    .div_whole  (div_whole_q),
    .div_frac   (div_frac_q),
    .pre_code   (pre_code_q),
    .osr_sel    (osr_sel_q)
);

// File: tb/test_baud_tick_gen.sv
// Self-checking bench for the baud tick generator: random configurations from a
// fixed seed plus directed corners, all against a tick-position model.
module test_baud_tick_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        tx_active = 1'b0;
    logic        coded_mode = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        os_tick;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen i_baud_tick_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tx_active  (tx_active),
        .coded_mode (coded_mode),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .os_tick    (os_tick),
        .bit_tick   (bit_tick)
    );

    function automatic int factor_of(input int code);
        return (code == 1) ? 8 : (code == 2) ? 3 : 16;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = 2'(addr);
        cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic set_cfg(input int pre, input int whole, input int frac, input int osr);
        cfg_write(2, pre);
        cfg_write(0, whole);
        cfg_write(1, frac);
        cfg_write(3, osr);
    endtask

    // Enable, then compare every cycle with the predicted tick positions until nticks are due.
    task automatic run_check(input string req, input int pre, input int whole, input int frac,
                             input int factor, input int nticks, output int last_t);
        int cyc, k, acc, exp_t, bad_os, bad_bit, first_bad;
        bit exp_os, exp_bit;
        cyc = 0; k = 0; acc = 0; bad_os = 0; bad_bit = 0; first_bad = -1;
        exp_t = (pre + 1) * (whole + (((acc + frac) >= 64) ? 1 : 0));
        @(negedge clk);
        enable = 1'b1;
        while (k < nticks) begin
            @(posedge clk);
            #1;
            cyc++;
            exp_os = (cyc == exp_t);
            exp_bit = 1'b0;
            if (exp_os) begin
                k++;
                exp_bit = ((k % factor) == 0);
                acc = (acc + frac) % 64;
                exp_t = exp_t + (pre + 1) * (whole + (((acc + frac) >= 64) ? 1 : 0));
                last_t = cyc;
            end
            if (os_tick != exp_os) begin
                bad_os++;
                if (first_bad < 0) first_bad = cyc;
            end
            if (bit_tick != exp_bit) bad_bit++;
        end
        @(negedge clk);
        enable = 1'b0;
        checks++;
        if (bad_os != 0) begin
            errors++;
            $display("FAIL %s os_tick: actual %0d mismatching cycles (first at %0d) expected 0", req, bad_os, first_bad);
        end
        check({req, " bit_tick mismatching cycles"}, bad_bit, 0);
    endtask

    // Enable for a stretch and count any ticks at all.
    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        @(negedge clk);
        enable = 1'b1;
        repeat (cycles) begin
            @(posedge clk);
            #1;
            if (os_tick || bit_tick) n++;
        end
        @(negedge clk);
        enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, t, pre, whole, frac, osr;
        void'($urandom(32'h1BAD5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        check("R8 os_tick after reset", int'(os_tick), 0);
        check("R8 bit_tick after reset", int'(bit_tick), 0);
        count_ticks(200, n);
        check("R8 R3 default whole zero gives no ticks", n, 0);
        cfg_write(0, 4);
        run_check("R8 defaults ratio1 frac0 x16", 0, 4, 0, 16, 32, t);

        // R3: zero whole part with a nonzero fraction
        set_cfg(0, 0, 37, 0);
        count_ticks(500, n);
        check("R3 zero whole part", n, 0);

        // R2 R7: whole part one at the largest prescaler, full fraction
        set_cfg(7, 1, 63, 2);
        run_check("R1 R2 R7 whole1 pre8 frac63 x3", 7, 1, 63, 3, 40, t);

        // R9: reference divisor
        set_cfg(0, 130, 13, 0);
        run_check("R9 reference divisor", 0, 130, 13, 16, 64, t);
        check("R9 R2 64-period total", t, 8333);

        // R1 R2 R4: random configurations
        for (int i = 0; i < 6; i++) begin
            pre   = int'($urandom_range(0, 7));
            whole = int'($urandom_range(2, 40));
            frac  = int'($urandom_range(0, 63));
            osr   = int'($urandom_range(0, 2));
            set_cfg(pre, whole, frac, osr);
            run_check("R1 R2 R4 random", pre, whole, frac, factor_of(osr), 24, t);
        end

        // R6: writes while enabled or while the transmitter is busy
        set_cfg(0, 5, 0, 1);
        @(negedge clk);
        enable = 1'b1;
        cfg_write(0, 9);
        cfg_write(2, 3);
        @(negedge clk);
        enable = 1'b0;
        tx_active = 1'b1;
        cfg_write(1, 40);
        cfg_write(3, 0);
        tx_active = 1'b0;
        run_check("R6 writes ignored when enabled or busy", 0, 5, 0, 8, 16, t);

        // R4: reserved oversampling code ignored
        cfg_write(3, 3);
        run_check("R4 reserved code ignored", 0, 5, 0, 8, 16, t);

        // R5: factor 3 refused under line coding, accepted otherwise
        coded_mode = 1'b1;
        cfg_write(3, 2);
        coded_mode = 1'b0;
        run_check("R5 x3 refused while coded", 0, 5, 0, 8, 16, t);
        cfg_write(3, 2);
        run_check("R4 R5 x3 accepted when not coded", 0, 5, 0, 3, 9, t);

        // R7: disabling in mid-period restarts the phase
        set_cfg(1, 10, 21, 0);
        @(negedge clk);
        enable = 1'b1;
        repeat (13) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        run_check("R7 restart after mid-period disable", 1, 10, 21, 16, 20, t);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule